// File: doc/BRIEF.md
# Local Interrupt Controller Timer

This block is the timer of a per-processor local interrupt controller, together with the small register file around it. A free-running base tick comes in from outside. The block divides that tick by a power of two chosen in software. It then counts down from a loaded start value. Each time a period runs out, it raises a one-cycle interrupt request that carries the vector held in the timer's vector-table entry.

Software uses a simple write port and a combinational read port to program three things:

- the timer entry, which holds the vector, a mask bit and a periodic/one-shot select;
- a divide setting;
- the start count.

Writing the start count begins a new period at once. The register file also holds the other reset-defined state of the local controller: the base-address word, task priority, spurious vector, destination mode and the remaining vector-table entries. Each of these comes out of reset at a fixed value.

Top module: `lic_timer`

## Requirements
- R1: After reset the registers read as follows.
  - Address 0 (base, read-only) reads 0xFEE00900 when IS_BSP=1 and 0xFEE00800 otherwise. Bit 11 is the enable bit and bit 8 is the bootstrap flag.
  - Address 1 (task priority) reads 0.
  - Address 2 (spurious vector) reads 0xFF.
  - Address 3 (destination mode) reads 0xF.
  - Address 4 (divide) reads 0.
  - Address 5 (start count) reads 0.
  - Address 6 (current count) reads 0.
  - The vector-table entries at addresses 8+i (entry 0 is the timer) read 0x00010000, which is masked. The exception is entry 1 on a bootstrap instance, which reads 0x00000700.
- R2: A write to address 1, 2, 3, 4, 5 or 8+i stores the full 32-bit word, and a read of that address returns the word. Writes to address 0 and address 6 have no effect.
- R3: The divide field is bits 2:0 of address 4. A value k makes one scaled tick out of every 2^k base ticks.
- R4: After the start count N is written, the first expiry falls on the (N+1)·2^k-th base tick. Address 6 reads N minus the number of scaled ticks seen so far in the current period.
- R5: In periodic mode (bit 17 of the timer entry set), expiries repeat every (N+1) scaled ticks for as long as the timer runs.
- R6: In one-shot mode (bit 17 clear), the timer expires once and then goes idle. Once idle, address 6 reads 0 and no further requests appear.
- R7: A start count of 0 produces no request in either mode, and address 6 then reads 0.
- R8: While mask bit 16 of the timer entry is set, an expiry produces no request. Counting continues, a periodic timer reloads, and a one-shot timer goes idle.
- R9: A divide change made in the middle of a period takes effect only at the next period boundary.
- R10: Writing the start count while the timer runs restarts the period from that write.
- R11: Each expiry gives exactly one cycle of irq_valid, with irq_vector equal to bits 7:0 of the timer entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Base timer tick, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_valid | output | 1 | One-cycle timer interrupt request |
| irq_vector | output | 8 | Vector carried by the request |

## Verification
The hardest situations to reach from the ports are the two that depend on a write landing partway through a running period:

- a divide change that must wait for the boundary;
- a masked expiry that must still reload, or still retire a one-shot timer.

The stimulus arranges these by stepping base ticks one at a time and placing register writes between chosen ticks. Each expiry is then located by tick index, and the current count is read back at points in between. This makes an expiry that is early or late by a single scaled tick show up directly.

// File: rtl/lic_timer_pkg.sv
package lic_timer_pkg;
    localparam int MASK_BIT = 16;
    localparam int MODE_BIT = 17;

    localparam logic [3:0] A_BASE  = 4'd0;
    localparam logic [3:0] A_TPRI  = 4'd1;
    localparam logic [3:0] A_SPUR  = 4'd2;
    localparam logic [3:0] A_DMODE = 4'd3;
    localparam logic [3:0] A_DIV   = 4'd4;
    localparam logic [3:0] A_START = 4'd5;
    localparam logic [3:0] A_CUR   = 4'd6;
    localparam int         A_LVT0  = 8;

    function automatic logic [31:0] lvt_reset(input int idx, input bit bsp);
        if (bsp && idx == 1) return 32'h0000_0700;
        return 32'h0001_0000;
    endfunction

    function automatic logic [31:0] base_reset(input bit bsp);
        return 32'hFEE0_0800 | (bsp ? 32'h0000_0100 : 32'h0);
    endfunction
endpackage

// File: rtl/lic_prescaler.sv
module lic_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] shift_i,
    output logic             scaled_o
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t s_d, s_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim      = {PRE_W{1'b1}} >> (PRE_W - int'(shift_i));
        scaled_o = tick_i && !restart_i && (s_q.cnt == lim);
        s_d      = s_q;
        if (restart_i)     s_d.cnt = '0;
        else if (scaled_o) s_d.cnt = '0;
        else if (tick_i)   s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_cnt_below_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= lim);
endmodule

// File: rtl/lic_countdown.sv
module lic_countdown #(
    parameter int CNT_W = 32,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             scaled_i,
    input  logic             periodic_i,
    input  logic             mask_i,
    input  logic [7:0]       vec_i,
    output logic [DIV_W-1:0] shift_o,
    output logic [CNT_W-1:0] current_o,
    output logic             irq_o,
    output logic [7:0]       irq_vec_o
);
    typedef struct packed {
        logic [CNT_W-1:0] remain;
        logic             active;
        logic [DIV_W-1:0] shift;
        logic             irq;
        logic [7:0]       vec;
    } cd_t;

    cd_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (load_i) begin
            s_d.remain = load_val_i;
            s_d.active = (load_val_i != '0);
            s_d.shift  = div_i;
        end else if (scaled_i && s_q.active) begin
            if (s_q.remain == '0) begin
                s_d.irq = !mask_i;
                s_d.vec = vec_i;
                if (periodic_i) begin
                    s_d.remain = start_i;
                    s_d.shift  = div_i;
                end else begin
                    s_d.active = 1'b0;
                end
            end else begin
                s_d.remain = s_q.remain - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign shift_o   = s_q.shift;
    assign current_o = s_q.active ? s_q.remain : '0;
    assign irq_o     = s_q.irq;
    assign irq_vec_o = s_q.vec;

    p_mask_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |-> $past(!mask_i));
    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |=> !s_q.irq);
    p_oneshot_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq && $past(!periodic_i)) |-> !s_q.active);
    p_zero_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i == '0) |=> !s_q.active);
    p_remain_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> (s_q.remain <= start_i));
endmodule

// File: rtl/lic_regfile.sv
module lic_regfile
    import lic_timer_pkg::*;
#(
    parameter bit IS_BSP  = 1'b1,
    parameter int NUM_LVT = 4,
    parameter int DIV_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [3:0]       rd_addr,
    input  logic [31:0]      current_i,
    output logic [31:0]      rd_data,
    output logic             load_o,
    output logic [31:0]      start_o,
    output logic [DIV_W-1:0] div_o,
    output logic [31:0]      timer_lvt_o
);
    typedef struct packed {
        logic [31:0]               tpri;
        logic [31:0]               spur;
        logic [31:0]               dmode;
        logic [31:0]               div;
        logic [31:0]               start;
        logic [NUM_LVT-1:0][31:0]  lvt;
    } rf_t;

    rf_t s_d, s_q, s_rst;

    always_comb begin
        s_rst       = '0;
        s_rst.spur  = 32'h0000_00FF;
        s_rst.dmode = 32'h0000_000F;
        for (int i = 0; i < NUM_LVT; i++) s_rst.lvt[i] = lvt_reset(i, IS_BSP);
    end

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_addr)
                A_TPRI:  s_d.tpri  = wr_data;
                A_SPUR:  s_d.spur  = wr_data;
                A_DMODE: s_d.dmode = wr_data;
                A_DIV:   s_d.div   = wr_data;
                A_START: s_d.start = wr_data;
                default: ;
            endcase
            for (int i = 0; i < NUM_LVT; i++)
                if (wr_addr == 4'(A_LVT0 + i)) s_d.lvt[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= s_rst;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_BASE:  rd_data = base_reset(IS_BSP);
            A_TPRI:  rd_data = s_q.tpri;
            A_SPUR:  rd_data = s_q.spur;
            A_DMODE: rd_data = s_q.dmode;
            A_DIV:   rd_data = s_q.div;
            A_START: rd_data = s_q.start;
            A_CUR:   rd_data = current_i;
            default: ;
        endcase
        for (int i = 0; i < NUM_LVT; i++)
            if (rd_addr == 4'(A_LVT0 + i)) rd_data = s_q.lvt[i];
    end

    assign load_o      = wr_en && (wr_addr == A_START);
    assign start_o     = s_q.start;
    assign div_o       = s_q.div[DIV_W-1:0];
    assign timer_lvt_o = s_q.lvt[0];

    p_start_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (s_q.start == $past(wr_data)));
endmodule

// File: rtl/lic_timer.sv
module lic_timer
    import lic_timer_pkg::*;
#(
    parameter bit IS_BSP  = 1'b1,
    parameter int NUM_LVT = 4,
    parameter int DIV_W   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_in,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [3:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        irq_valid,
    output logic [7:0]  irq_vector
);
    logic             load;
    logic [31:0]      start;
    logic [DIV_W-1:0] div_cfg;
    logic [DIV_W-1:0] act_shift;
    logic [31:0]      timer_lvt;
    logic [31:0]      current;
    logic             scaled;

    lic_regfile #(.IS_BSP(IS_BSP), .NUM_LVT(NUM_LVT), .DIV_W(DIV_W)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .current_i(current), .rd_data(rd_data),
        .load_o(load), .start_o(start), .div_o(div_cfg),
        .timer_lvt_o(timer_lvt)
    );

    lic_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_in), .restart_i(load),
        .shift_i(act_shift), .scaled_o(scaled)
    );

    lic_countdown #(.CNT_W(32), .DIV_W(DIV_W)) u_cd (
        .clk(clk), .rst_n(rst_n),
        .load_i(load), .load_val_i(wr_data), .start_i(start),
        .div_i(div_cfg), .scaled_i(scaled),
        .periodic_i(timer_lvt[MODE_BIT]), .mask_i(timer_lvt[MASK_BIT]),
        .vec_i(timer_lvt[7:0]),
        .shift_o(act_shift), .current_o(current),
        .irq_o(irq_valid), .irq_vec_o(irq_vector)
    );
endmodule

// File: tb/tb_lic_timer.sv
`timescale 1ns/100ps
module tb_lic_timer;
    logic clk = 1'b0, rst_n = 1'b0, tick_in = 1'b0, wr_en = 1'b0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic irq_valid;
    logic [7:0] irq_vector;
    int checks = 0, errors = 0;
    int n_fire, first_fire;
    logic [7:0] last_vec;
    bit done = 0;

    always #2.5 clk = ~clk;

    lic_timer dut (.clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector));

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] e);
        @(negedge clk); rd_addr = a; #1;
        chk(req, rd_data, e);
    endtask

    task automatic run_ticks(input int n);
        n_fire = 0; first_fire = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk); tick_in = 1;
            @(negedge clk); tick_in = 0;
            if (irq_valid) begin
                n_fire++; last_vec = irq_vector;
                if (first_fire == 0) first_fire = i;
            end
        end
    endtask

    function automatic logic [31:0] ent(input bit per, input bit msk, input logic [7:0] v);
        return {14'd0, per, msk, 8'd0, v};
    endfunction

    localparam int NV = 7;
    localparam int V_PER  [NV] = '{1, 0, 1, 0, 1, 1, 0};
    localparam int V_MSK  [NV] = '{0, 0, 0, 0, 0, 1, 0};
    localparam int V_SH   [NV] = '{0, 0, 2, 1, 0, 0, 3};
    localparam int V_INIT [NV] = '{3, 3, 1, 0, 0, 2, 2};
    localparam int V_NT   [NV] = '{12, 12, 16, 10, 10, 9, 30};
    localparam int V_CNT  [NV] = '{3, 1, 2, 0, 0, 0, 1};
    localparam int V_FST  [NV] = '{4, 4, 8, 0, 0, 0, 24};

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd_chk("R1 base", 4'd0, 32'hFEE0_0900);
        rd_chk("R1 tpri", 4'd1, 32'h0);
        rd_chk("R1 spur", 4'd2, 32'hFF);
        rd_chk("R1 dmode", 4'd3, 32'hF);
        rd_chk("R1 div", 4'd4, 32'h0);
        rd_chk("R1 start", 4'd5, 32'h0);
        rd_chk("R1 cur", 4'd6, 32'h0);
        rd_chk("R1 lvt timer", 4'd8, 32'h0001_0000);
        rd_chk("R1 lvt lint0", 4'd9, 32'h0000_0700);
        rd_chk("R1 lvt2", 4'd10, 32'h0001_0000);
        chk("R1 irq idle", irq_valid, 0);

        // R2 readback and read-only
        wr(4'd1, 32'h0000_0042); rd_chk("R2 tpri", 4'd1, 32'h42);
        wr(4'd11, 32'hA5A5_1234); rd_chk("R2 lvt3", 4'd11, 32'hA5A5_1234);
        wr(4'd0, 32'h0); rd_chk("R2 base ro", 4'd0, 32'hFEE0_0900);
        wr(4'd6, 32'h55); rd_chk("R2 cur ro", 4'd6, 32'h0);

        // vector table: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            wr(4'd8, ent(V_PER[v] != 0, V_MSK[v] != 0, 8'(8'h30 + v)));
            wr(4'd4, 32'(V_SH[v]));
            wr(4'd5, 32'(V_INIT[v]));
            run_ticks(V_NT[v]);
            chk($sformatf("R5 R6 R7 R8 count v%0d", v), n_fire, V_CNT[v]);
            chk($sformatf("R3 R4 first v%0d", v), first_fire, V_FST[v]);
            if (V_CNT[v] > 0) chk($sformatf("R11 vec v%0d", v), last_vec, 8'(8'h30 + v));
        end

        // R4 current count readback, R6 idle
        wr(4'd8, ent(0, 0, 8'h77)); wr(4'd4, 0); wr(4'd5, 5);
        run_ticks(2); rd_chk("R4 cur mid", 4'd6, 32'd3);
        run_ticks(4); chk("R6 fire at 6", first_fire, 4);
        chk("R11 vector", last_vec, 8'h77);
        rd_chk("R6 cur idle", 4'd6, 32'd0);
        run_ticks(8); chk("R6 no refire", n_fire, 0);

        // R3 scaled count
        wr(4'd4, 2); wr(4'd5, 3);
        run_ticks(4); rd_chk("R3 cur scaled", 4'd6, 32'd2);

        // R9 divide change at boundary
        wr(4'd8, ent(1, 0, 8'h21)); wr(4'd4, 0); wr(4'd5, 1);
        run_ticks(1); wr(4'd4, 1);
        run_ticks(1); chk("R9 old period", first_fire, 1);
        run_ticks(3); chk("R9 new period early", n_fire, 0);
        run_ticks(1); chk("R9 new period", first_fire, 1);

        // R10 restart
        wr(4'd4, 0); wr(4'd5, 3);
        run_ticks(2); wr(4'd5, 3);
        run_ticks(3); chk("R10 no early", n_fire, 0);
        run_ticks(1); chk("R10 restart fire", first_fire, 1);

        // R8 masked periodic keeps reloading
        wr(4'd8, ent(1, 1, 8'h21)); wr(4'd5, 1);
        run_ticks(2); chk("R8 masked", n_fire, 0);
        wr(4'd8, ent(1, 0, 8'h21));
        run_ticks(2); chk("R8 unmask phase", first_fire, 2);

        // R8 masked one-shot retires
        wr(4'd8, ent(0, 1, 8'h22)); wr(4'd5, 2);
        run_ticks(3); chk("R8 oneshot masked", n_fire, 0);
        rd_chk("R8 oneshot idle", 4'd6, 32'd0);
        wr(4'd8, ent(0, 0, 8'h22));
        run_ticks(4); chk("R8 no late fire", n_fire, 0);

        // R7 zero stops a running timer
        wr(4'd8, ent(1, 0, 8'h23)); wr(4'd5, 2); run_ticks(1);
        wr(4'd5, 0); run_ticks(6);
        chk("R7 zero stop", n_fire, 0);
        rd_chk("R7 cur zero", 4'd6, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule